// File: doc/BRIEF.md
# Bidirectional Cascadable Gate Scan Register

This block scans the gate rows of a thin-film-transistor panel. A start pulse enters at one end of a chain of stages, one stage per gate row. On every rising edge of the shift clock the pulse moves one stage further along. A direction input selects which end is the entry. The last stage is handed on as a cascade pulse to the next chip in a daisy chain. Several chips chained this way cover a panel taller than one chip's row count.

Each end of the chain has one bidirectional start-pulse pin. Here each pin is split into an input, an output and a drive-enable. The direction input enables exactly one of the two pins as a driver; the other pin acts as the start input. The cascade pulse is registered on the falling edge of the shift clock. This gives the next chip half a period of setup before its own rising edge.

The gate outputs are logic-level enables. Each one is blanked by one of three interleaved mask phases, chosen by row index modulo 3. Level shifting and high-voltage drive are outside the block. The stage array and the start-pulse pins carry no flow control and are plain synchronous signals.

Top module: `gscan_top`

## Requirements
- R1: While `rst_n` is low, asynchronously and without a clock, every stage and the cascade register read 0. So all `gate_on` bits and both start-pulse outputs are 0.
- R2: With `dir_fwd` high, each rising clock edge captures `sp_a_in` into the row 1 stage (`gate_on[0]`), and every stage k takes the old value of stage k-1. `sp_b_in` has no effect.
- R3: With `dir_fwd` low, each rising clock edge captures `sp_b_in` into the row NUM_ROWS stage (`gate_on[NUM_ROWS-1]`), and every stage k takes the old value of stage k+1. `sp_a_in` has no effect.
- R4: With `dir_fwd` high, `sp_b_out` takes the row NUM_ROWS stage value on each falling clock edge. A pulse captured at rising edge 1 therefore leaves on the falling edge that follows rising edge NUM_ROWS.
- R5: With `dir_fwd` low, `sp_a_out` takes the row 1 stage value on each falling clock edge, with the same NUM_ROWS-edge latency.
- R6: `sp_b_oe` equals `dir_fwd` and `sp_a_oe` equals its inverse, combinationally, so exactly one pin is driven.
- R7: `gate_on[i]` is 1 only when stage i holds 1 and `gate_mask[i mod 3]` is 0. Mask bit 0 covers rows 1, 4, 7, …, bit 1 covers rows 2, 5, …, and bit 2 covers rows 3, 6, …. A high mask bit forces its rows to 0. Masking is combinational; stage contents change only on rising edges.
- R8: A start input held high for several clocks fills that many consecutive stages with 1. Each of these stages is masked on its own by its phase.
- R9: The row count is the parameter NUM_ROWS (default 256, at least 2). The modulo-3 phase mapping holds for any value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_fwd | input | 1 | 1: scan row 1 toward row NUM_ROWS; 0: reverse |
| sp_a_in | input | 1 | Row-1-side start pin, input value |
| sp_a_out | output | 1 | Row-1-side start pin, driven value (reverse cascade) |
| sp_a_oe | output | 1 | Row-1-side start pin drive enable |
| sp_b_in | input | 1 | Row-NUM_ROWS-side start pin, input value |
| sp_b_out | output | 1 | Row-NUM_ROWS-side start pin, driven value (forward cascade) |
| sp_b_oe | output | 1 | Row-NUM_ROWS-side start pin drive enable |
| gate_mask | input | 3 | Per-phase blanking, high forces rows of that phase off |
| gate_on | output | NUM_ROWS | Gate row enables, bit i is row i+1 |

## Verification
The bench builds the block with NUM_ROWS = 7. This count is not a multiple of three, so the last row falls on phase 0 and the phase wrap is exercised at both ends of the chain. Seven stages also let a pulse cross the whole chain and leave through the cascade pin in a few clocks. Single pulses, irregular pulse trains and held-high inputs run in both directions. The mask input cycles through all eight values. The unused start pin is driven with the complement of the active one.

// File: rtl/gscan_pkg.sv
package gscan_pkg;
  localparam int unsigned NUM_PHASES = 3;

  // Mask phase of a zero-based row index (row i+1 in one-based numbering).
  function automatic int unsigned phase_of(input int unsigned row_idx);
    return row_idx % NUM_PHASES;
  endfunction
endpackage

// File: rtl/gscan_chain.sv
module gscan_chain #(
  parameter int unsigned NUM_ROWS = 256
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                dir_fwd,
  input  logic                a_in,
  input  logic                b_in,
  output logic [NUM_ROWS-1:0] stage_q
);
  localparam int unsigned LAST = NUM_ROWS - 1;

  logic [NUM_ROWS-1:0] fwd_src;
  logic [NUM_ROWS-1:0] rev_src;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_ROWS; gi++) begin : g_src
      if (gi == 0) begin : g_head
        assign fwd_src[gi] = a_in;
      end else begin : g_mid_f
        assign fwd_src[gi] = stage_q[gi-1];
      end
      if (gi == LAST) begin : g_tail
        assign rev_src[gi] = b_in;
      end else begin : g_mid_r
        assign rev_src[gi] = stage_q[gi+1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= dir_fwd ? fwd_src : rev_src;
  end
endmodule

// File: rtl/gscan_cascade.sv
module gscan_cascade (
  input  logic clk,
  input  logic rst_n,
  input  logic dir_fwd,
  input  logic first_row,
  input  logic last_row,
  output logic a_out,
  output logic a_oe,
  output logic b_out,
  output logic b_oe
);
  logic casc_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) casc_q <= 1'b0;
    else        casc_q <= dir_fwd ? last_row : first_row;
  end

  assign a_out = casc_q;
  assign b_out = casc_q;
  assign a_oe  = ~dir_fwd;
  assign b_oe  = dir_fwd;
endmodule

// File: rtl/gscan_mask.sv
module gscan_mask
  import gscan_pkg::*;
#(
  parameter int unsigned NUM_ROWS = 256
) (
  input  logic [NUM_ROWS-1:0]   stage_q,
  input  logic [NUM_PHASES-1:0] gate_mask,
  output logic [NUM_ROWS-1:0]   gate_on
);
  genvar gi;
  generate
    for (gi = 0; gi < NUM_ROWS; gi++) begin : g_row
      localparam int unsigned PH = phase_of(gi);
      assign gate_on[gi] = stage_q[gi] & ~gate_mask[PH];
    end
  endgenerate
endmodule

// File: rtl/gscan_top.sv
module gscan_top
  import gscan_pkg::*;
#(
  parameter int unsigned NUM_ROWS = 256
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                dir_fwd,
  input  logic                sp_a_in,
  output logic                sp_a_out,
  output logic                sp_a_oe,
  input  logic                sp_b_in,
  output logic                sp_b_out,
  output logic                sp_b_oe,
  input  logic [2:0]          gate_mask,
  output logic [NUM_ROWS-1:0] gate_on
);
  logic [NUM_ROWS-1:0] stage_q;

  gscan_chain #(.NUM_ROWS(NUM_ROWS)) u_chain (
    .clk     (clk),
    .rst_n   (rst_n),
    .dir_fwd (dir_fwd),
    .a_in    (sp_a_in),
    .b_in    (sp_b_in),
    .stage_q (stage_q)
  );

  gscan_cascade u_casc (
    .clk       (clk),
    .rst_n     (rst_n),
    .dir_fwd   (dir_fwd),
    .first_row (stage_q[0]),
    .last_row  (stage_q[NUM_ROWS-1]),
    .a_out     (sp_a_out),
    .a_oe      (sp_a_oe),
    .b_out     (sp_b_out),
    .b_oe      (sp_b_oe)
  );

  gscan_mask #(.NUM_ROWS(NUM_ROWS)) u_mask (
    .stage_q   (stage_q),
    .gate_mask (gate_mask),
    .gate_on   (gate_on)
  );
endmodule

// File: rtl/gscan_chk.sv
module gscan_chk #(
  parameter int unsigned NUM_ROWS = 256
) (
  input logic                clk,
  input logic                rst_n,
  input logic                dir_fwd,
  input logic                sp_a_in,
  input logic                sp_b_in,
  input logic                sp_a_out,
  input logic                sp_b_out,
  input logic                sp_a_oe,
  input logic                sp_b_oe,
  input logic [2:0]          gate_mask,
  input logic [NUM_ROWS-1:0] stage_q,
  input logic [NUM_ROWS-1:0] gate_on
);
  assert_one_driver_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_b_oe == dir_fwd) && (sp_a_oe != sp_b_oe));

  assert_fwd_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dir_fwd |=> stage_q[0] == $past(sp_a_in));

  assert_rev_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_fwd |=> stage_q[NUM_ROWS-1] == $past(sp_b_in));

  assert_fwd_casc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_fwd && $stable(dir_fwd)) |-> sp_b_out == stage_q[NUM_ROWS-1]);

  assert_rev_casc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_fwd && $stable(dir_fwd)) |-> sp_a_out == stage_q[0]);

  genvar gi;
  generate
    for (gi = 0; gi < NUM_ROWS; gi++) begin : g_chk
      assert_masked_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        gate_mask[gi % 3] |-> !gate_on[gi]);
      if (gi > 0) begin : g_f
        assert_fwd_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
          dir_fwd |=> stage_q[gi] == $past(stage_q[gi-1]));
      end
      if (gi < NUM_ROWS - 1) begin : g_r
        assert_rev_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
          !dir_fwd |=> stage_q[gi] == $past(stage_q[gi+1]));
      end
    end
  endgenerate

  always_comb begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (gate_on == '0);
    end
  end
endmodule

bind gscan_top gscan_chk #(.NUM_ROWS(NUM_ROWS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dir_fwd   (dir_fwd),
  .sp_a_in   (sp_a_in),
  .sp_b_in   (sp_b_in),
  .sp_a_out  (sp_a_out),
  .sp_b_out  (sp_b_out),
  .sp_a_oe   (sp_a_oe),
  .sp_b_oe   (sp_b_oe),
  .gate_mask (gate_mask),
  .stage_q   (stage_q),
  .gate_on   (gate_on)
);

// File: tb/tb_gscan_top.sv
`timescale 1ns/1ps
module tb_gscan_top;
  localparam int N = 7;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         dir_fwd = 1'b1;
  logic         sp_a_in = 1'b0;
  logic         sp_b_in = 1'b0;
  logic [2:0]   gate_mask = 3'b000;
  logic         sp_a_out, sp_a_oe, sp_b_out, sp_b_oe;
  logic [N-1:0] gate_on;

  int checks = 0;
  int fails  = 0;
  bit pat [0:63];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gscan_top #(.NUM_ROWS(N)) dut (
    .clk(clk), .rst_n(rst_n), .dir_fwd(dir_fwd),
    .sp_a_in(sp_a_in), .sp_a_out(sp_a_out), .sp_a_oe(sp_a_oe),
    .sp_b_in(sp_b_in), .sp_b_out(sp_b_out), .sp_b_oe(sp_b_oe),
    .gate_mask(gate_mask), .gate_on(gate_on)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Stage (0-based row) content after rising edge t: the input applied at
  // edge t-d, where d is the row's distance from the entry end.
  function automatic bit exp_stage(input bit fwd, input int row, input int t);
    int d = fwd ? row : (N - 1 - row);
    int idx = t - d;
    return (idx >= 1) ? pat[idx] : 1'b0;
  endfunction

  task automatic do_reset();
    @(negedge clk); #1;
    rst_n = 1'b0;
    #1;
    check("R1 gates in reset", gate_on, '0);
    check("R1 casc a in reset", sp_a_out, 1'b0);
    check("R1 casc b in reset", sp_b_out, 1'b0);
    @(negedge clk); #1;
    rst_n = 1'b1;
  endtask

  task automatic run(input bit fwd, input int kind, input int len, input int seed);
    for (int t = 1; t < 64; t++) begin
      case (kind)
        0: pat[t] = (t == 1);
        1: pat[t] = (((t * 5 + seed) % 7) < 3) && (t <= len - N);
        default: pat[t] = (t >= 2 && t <= 4);
      endcase
    end
    do_reset();
    dir_fwd = fwd;
    #1;
    check(fwd ? "R6 b_oe fwd" : "R6 b_oe rev", {sp_a_oe, sp_b_oe}, fwd ? 2'b01 : 2'b10);
    for (int t = 1; t <= len; t++) begin
      logic [N-1:0] exp_g;
      logic [N-1:0] exp_raw;
      // active start pin carries the pattern, the other its complement (ignored)
      if (fwd) begin sp_a_in = pat[t]; sp_b_in = ~pat[t]; end
      else     begin sp_b_in = pat[t]; sp_a_in = ~pat[t]; end
      gate_mask = 3'((t + seed) % 8);
      @(posedge clk); #1;
      for (int r = 0; r < N; r++) begin
        exp_raw[r] = exp_stage(fwd, r, t);
        exp_g[r] = exp_raw[r] & ~gate_mask[r % 3];
      end
      check(fwd ? "R2 R7 R8 R9 fwd gates" : "R3 R7 R8 R9 rev gates", gate_on, exp_g);
      // unmasked view of the stages through the normal interface
      gate_mask = 3'b000;
      #0.5;
      check(fwd ? "R2 fwd stages" : "R3 rev stages", gate_on, exp_raw);
      @(negedge clk); #1;
      if (fwd) check("R4 fwd cascade", sp_b_out, exp_stage(1'b1, N - 1, t));
      else     check("R5 rev cascade", sp_a_out, exp_stage(1'b0, 0, t));
    end
  endtask

  initial begin
    #50000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #1;
    check("R1 gates at start", gate_on, '0);
    run(1'b1, 0, N + 3, 0);
    run(1'b0, 0, N + 3, 1);
    run(1'b1, 1, N + 14, 2);
    run(1'b0, 1, N + 14, 5);
    run(1'b1, 2, N + 6, 3);
    run(1'b0, 2, N + 6, 6);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule